// File: doc/BRIEF.md
# Blanked Fault Supervisor for a Synchronous Gate-Driver Pair

This block watches three fault indications that external comparators have already turned into logic levels: a supply undervoltage, an over-temperature warning and an input-voltage undervoltage. Each indication must stay high for a programmable number of consecutive clock cycles before it counts as a fault. This blanking makes the block ignore short glitches. A qualified fault raises a combined fault flag and disables both gate drivers. A qualified input undervoltage also asks for the soft-start node to be discharged, so that the next restart begins from zero duty.

An active-low shutdown input disables the drivers and requests the soft-start discharge, just as an input undervoltage does, but it does not raise the fault flag. A fault is removed on the first clock edge where its raw input is sampled low; release is not blanked. After a synchronous reset the block holds itself faulted until it samples the supply undervoltage input low once.

All three outputs are plain level signals. The drivers downstream simply obey the disable level and the soft-start circuit obeys the discharge level.

Top module: `fault_supervisor`

## Requirements
- R1: While `rst` is high, and after it until `sup_uv_raw` is sampled low, `fault`, `drv_disable` and `ss_discharge` are all 1.
- R2: The start-up hold clears on the first rising edge after reset where `sup_uv_raw` is 0. From the following cycle on, all three outputs are 0 when no fault is qualified and `shutdown_n` is 1.
- R3: A supply undervoltage qualifies at the SUP_BLANK-th consecutive rising edge that samples `sup_uv_raw` as 1, and not earlier.
- R4: An over-temperature qualifies at the OT_BLANK-th consecutive rising edge that samples `temp_hi_raw` as 1, and not earlier.
- R5: An input undervoltage qualifies at the VIN_BLANK-th consecutive rising edge that samples `vin_uv_raw` as 1, and not earlier.
- R6: A raw run shorter than its blanking length changes no output. Any low sample restarts the count from zero, so a later run needs the full length again.
- R7: A qualified fault clears at the first rising edge that samples its raw input as 0.
- R8: `drv_disable` is 1 in every cycle where `fault` is 1.
- R9: `ss_discharge` follows a qualified input undervoltage. A qualified supply undervoltage or over-temperature alone leaves it at 0.
- R10: `shutdown_n` = 0 sets `drv_disable` and `ss_discharge` to 1 in the same cycle, without a clock edge, and leaves `fault` unchanged.
- R11: `fault` stays 1 while at least one fault is qualified, including across a cycle where one fault clears while another qualifies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sup_uv_raw | input | 1 | Supply undervoltage from a comparator, 1 = low supply |
| temp_hi_raw | input | 1 | Over-temperature from a comparator, 1 = hot |
| vin_uv_raw | input | 1 | Input undervoltage from a comparator, 1 = input too low |
| shutdown_n | input | 1 | Shutdown request, active low |
| fault | output | 1 | Combined qualified-fault flag, including the start-up hold |
| ss_discharge | output | 1 | Request to hold the soft-start node discharged |
| drv_disable | output | 1 | Forces both gate drivers into the sinking state |

## Verification
Two events can fall on the same rising edge: one fault releasing and another completing its blanking. The bench qualifies the over-temperature fault first. It then holds the input undervoltage high and drops the over-temperature input in exactly the cycle before the input undervoltage count finishes. Both events therefore land on one edge, and `fault` must stay 1 through that edge with no one-cycle gap, while `ss_discharge` rises at that same edge. The same sweep also places a fresh run directly after a short run, separated by one low cycle, to check that the blanking counter restarted.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int NCH    = 3;
  localparam int CH_SUP = 0;
  localparam int CH_OT  = 1;
  localparam int CH_VIN = 2;
  typedef logic [NCH-1:0] fault_vec_t;
endpackage

// File: rtl/fsup_blank_filter.sv
module fsup_blank_filter #(
  parameter int BLANK = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic qual
);
  localparam int CW = $clog2(BLANK + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else if (!raw) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else if (!qual) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(BLANK - 1)) qual <= 1'b1;
    end
  end

  // R7: release on first low sample
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    !raw |=> !qual);
  // R3 R4 R5: qualification only after a full run (R6: restart on low)
  p_full_run_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(qual) |-> (cnt == CW'(BLANK)) && $past(raw));
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(BLANK));
endmodule

// File: rtl/fsup_combine.sv
module fsup_combine
  import fsup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sup_raw,
  input  fault_vec_t qual,
  input  logic       shutdown_n,
  output logic       fault,
  output logic       ss_discharge,
  output logic       drv_disable
);
  logic boot_hold;

  always_ff @(posedge clk) begin
    if (rst)           boot_hold <= 1'b1;
    else if (!sup_raw) boot_hold <= 1'b0;
  end

  always_comb begin
    fault        = boot_hold | (|qual);
    ss_discharge = boot_hold | qual[CH_VIN] | ~shutdown_n;
    drv_disable  = fault | ~shutdown_n;
  end

  // R2: hold only leaves after a low supply-undervoltage sample
  p_boot_exit_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(boot_hold) |-> $past(!sup_raw));
  p_boot_stays_r1: assert property (@(posedge clk) disable iff (rst)
    (boot_hold && sup_raw) |=> boot_hold);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int SUP_BLANK = 3000,
  parameter int OT_BLANK  = 3000,
  parameter int VIN_BLANK = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_uv_raw,
  input  logic temp_hi_raw,
  input  logic vin_uv_raw,
  input  logic shutdown_n,
  output logic fault,
  output logic ss_discharge,
  output logic drv_disable
);
  localparam int BL [NCH] = '{SUP_BLANK, OT_BLANK, VIN_BLANK};

  fault_vec_t raw_v, qual_v;
  assign raw_v[CH_SUP] = sup_uv_raw;
  assign raw_v[CH_OT]  = temp_hi_raw;
  assign raw_v[CH_VIN] = vin_uv_raw;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    fsup_blank_filter #(.BLANK(BL[i])) u_flt (
      .clk (clk),
      .rst (rst),
      .raw (raw_v[i]),
      .qual(qual_v[i])
    );
  end

  fsup_combine u_cmb (
    .clk         (clk),
    .rst         (rst),
    .sup_raw     (sup_uv_raw),
    .qual        (qual_v),
    .shutdown_n  (shutdown_n),
    .fault       (fault),
    .ss_discharge(ss_discharge),
    .drv_disable (drv_disable)
  );

  // R8: a flagged fault always disables the drivers
  p_fault_disables_r8: assert property (@(posedge clk) disable iff (rst)
    qual_v != '0 |-> drv_disable && fault);
  // R9: discharge request tracks the input-undervoltage qualifier
  p_vin_discharge_r9: assert property (@(posedge clk) disable iff (rst)
    qual_v[CH_VIN] |-> ss_discharge);
  // R10: shutdown acts on the drivers
  p_shutdown_r10: assert property (@(posedge clk) disable iff (rst)
    !shutdown_n |-> drv_disable && ss_discharge);
endmodule

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  localparam int SB = 6, OB = 5, VB = 3;
  localparam int BLK [3] = '{SB, OB, VB};

  logic clk = 1'b0, rst = 1'b1, shutdown_n = 1'b1;
  logic [2:0] raw = 3'b000;
  logic fault, ss_discharge, drv_disable;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fault_supervisor #(.SUP_BLANK(SB), .OT_BLANK(OB), .VIN_BLANK(VB)) u0 (
    .clk(clk), .rst(rst), .sup_uv_raw(raw[0]), .temp_hi_raw(raw[1]),
    .vin_uv_raw(raw[2]), .shutdown_n(shutdown_n), .fault(fault),
    .ss_discharge(ss_discharge), .drv_disable(drv_disable));

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {fault,ss,drv} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] outs();
    return {fault, ss_discharge, drv_disable};
  endfunction

  // one channel high for len edges, then low for one edge
  task automatic pulse(input int ch, input int len);
    for (int n = 1; n <= len; n++) begin
      raw[ch] = 1'b1;
      @(negedge clk);
      begin
        logic q;
        q = (n >= BLK[ch]);
        // R3 R4 R5 qualification, R6 short runs, R8 disable, R9 discharge
        chk(ch == 0 ? "R3" : ch == 1 ? "R4" : "R5", outs(), {q, q && ch == 2, q});
      end
    end
    raw[ch] = 1'b0;
    @(negedge clk);
    chk("R7", outs(), 3'b000);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    raw = 3'b001;
    repeat (3) @(negedge clk);
    chk("R1", outs(), 3'b111);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", outs(), 3'b111);
    raw = 3'b000;
    @(negedge clk);
    chk("R2", outs(), 3'b000);
    @(negedge clk);

    // exhaustive run-length sweep per channel; consecutive runs also check R6 restart
    for (int ch = 0; ch < 3; ch++)
      for (int len = 1; len <= BLK[ch] + 2; len++) pulse(ch, len);

    // R6: short run, one low sample, then a full run qualifies exactly at BLK
    pulse(1, OB - 1);
    pulse(1, OB);

    // R11: OT qualified, then VIN qualifies on the edge where OT releases
    raw[1] = 1'b1;
    repeat (OB) @(negedge clk);
    chk("R11", outs(), 3'b101);
    raw[2] = 1'b1;
    repeat (VB - 1) @(negedge clk);
    chk("R11", outs(), 3'b101);
    raw[1] = 1'b0;
    @(negedge clk);
    chk("R11", outs(), 3'b111);
    raw[2] = 1'b0;
    @(negedge clk);
    chk("R11", outs(), 3'b000);

    // R10: shutdown acts without a clock edge and leaves fault alone
    shutdown_n = 1'b0;
    #1;
    chk("R10", outs(), 3'b011);
    @(negedge clk);
    chk("R10", outs(), 3'b011);
    shutdown_n = 1'b1;
    #1;
    chk("R10", outs(), 3'b000);

    // R9: supply-undervoltage and over-temperature together give no discharge request
    raw = 3'b011;
    repeat (SB) @(negedge clk);
    chk("R9", outs(), 3'b101);
    raw = 3'b000;
    @(negedge clk);
    chk("R7", outs(), 3'b000);

    // R1: a new reset brings the start-up hold back
    rst = 1'b1;
    raw = 3'b001;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", outs(), 3'b111);
    raw = 3'b000;
    @(negedge clk);
    chk("R2", outs(), 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule